// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block turns a chain of scatter-gather descriptors in memory into a single byte stream for a hash core. Software places descriptors back to back in memory, gives the block the address of the first one and the total message size, and pulses start. The walker reads each descriptor, then reads the described buffer with aligned 32-bit reads and hands the bytes one at a time over a valid/ready stream. The buffers come out joined in descriptor order, with no gaps and no repeats.

The walk ends at the descriptor whose length word carries the final marker, not after a fixed count. When the last byte has been taken, the walker pulses done. Alongside done it reports whether the descriptor lengths added up to the expected total. It also reports whether the consumer must still append message padding. In accumulative mode the buffers already hold their padding, so the bytes pass through unchanged and no padding is requested. Hashing, padding and digest write-back are handled elsewhere.

Top module: `sg_stream_walker`

## Requirements
- R1: After reset, out_valid, mem_req_valid, busy, done, len_error and pad_needed are all low.
- R2: A descriptor is 8 bytes, read as two little-endian 32-bit words: the length word at the descriptor address and the buffer address word at descriptor address + 4. Descriptors lie one after another from list_base, with a stride of 8 bytes.
- R3: Bit 31 of the length word marks the final descriptor, and the buffer length is bits 30:0. No descriptor after the marked one is read or streamed.
- R4: Bytes leave in descriptor order, and within a buffer in ascending address order. The byte at address A is taken from bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word read from A with its two low bits cleared.
- R5: A buffer may start at any byte address. Every memory request address has bits 1:0 equal to zero.
- R6: out_last is high only on the final byte of the final descriptor's buffer. If the final buffer is empty, no byte carries out_last.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold, and no memory request is raised. No byte is dropped or repeated under any pattern of back-pressure.
- R8: busy is high from the cycle after an accepted start until the walk completes. done is then a single-cycle pulse, raised when busy has fallen.
- R9: len_error is set together with done when the sum of descriptor lengths differs from total_len. It holds until the next accepted start, which clears it.
- R10: pad_needed is set together with done to the inverse of accum_mode as sampled at start. The byte stream is the same in both modes.
- R11: A descriptor with length zero produces no bytes and no data read. The walk goes on to the next descriptor, or finishes if the empty descriptor is the final one.
- R12: A start pulse while busy is ignored and does not change the current walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| list_base | input | AW | Address of the first descriptor |
| total_len | input | TOT_W | Expected byte count over all buffers |
| accum_mode | input | 1 | Buffers already carry padding |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data valid (one request outstanding) |
| mem_rsp_data | input | WORD_W | Read data, little-endian lanes |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the message |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| len_error | output | 1 | Length sum differed from total_len |
| pad_needed | output | 1 | Consumer must append padding |

## Verification
The bench builds the walker with AW=32, BUF_W=31, WORD_W=32 and a narrowed TOT_W=16. The full 31-bit length field and 32-bit buffer pointers are therefore decoded exactly as in deployment, while the total-length comparison uses zero extension across unequal widths. Memory holds only 2 KB, so buffers of up to 64 bytes at every lane offset can be laid out densely. Random ready patterns on both the memory and the stream side, with random memory latency, exercise every stall point of the fetch sequence.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   localparam int unsigned SGW_LANE_W      = 8;
   localparam int unsigned SGW_DESC_STRIDE = 8;
   localparam int unsigned SGW_PTR_OFFSET  = 4;
   localparam int unsigned SGW_FINAL_BIT   = 31;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LEN_REQ,
      ST_LEN_WAIT,
      ST_PTR_REQ,
      ST_PTR_WAIT,
      ST_DAT_REQ,
      ST_DAT_WAIT,
      ST_EMIT,
      ST_FINISH
   } sgw_state_e;
endpackage

// File: rtl/sgw_lane_pick.sv
module sgw_lane_pick #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LANES = WORD_W / LANE_W,
   localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SEL_W-1:0]  sel,
   output logic [LANE_W-1:0] lane_out
);
   if (WORD_W % LANE_W != 0) begin : g_bad_split
      $error("sgw_lane_pick: WORD_W must be a multiple of LANE_W");
   end

   logic [LANE_W-1:0] lanes [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word[g*LANE_W +: LANE_W];
   end

   assign lane_out = lanes[sel];
endmodule

// File: rtl/sgw_len_audit.sv
module sgw_len_audit #(
   parameter int unsigned BUF_W = 31,
   parameter int unsigned TOT_W = 28,
   localparam int unsigned SUM_W = ((BUF_W > TOT_W) ? BUF_W : TOT_W) + 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add_en,
   input  logic [BUF_W-1:0] add_len,
   input  logic [TOT_W-1:0] total,
   output logic             mismatch
);
   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (clear) begin
         sum_q <= '0;
      end else if (add_en) begin
         sum_q <= sum_q + SUM_W'(add_len);
      end
   end

   assign mismatch = (sum_q != SUM_W'(total));
endmodule

// File: rtl/sg_stream_walker.sv
module sg_stream_walker
   import sgw_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned BUF_W  = 31,
   parameter int unsigned TOT_W  = 28,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     list_base,
   input  logic [TOT_W-1:0]  total_len,
   input  logic              accum_mode,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              busy,
   output logic              done,
   output logic              len_error,
   output logic              pad_needed
);
   localparam int unsigned LANES = WORD_W / SGW_LANE_W;
   localparam int unsigned SEL_W = $clog2(LANES);

   if (WORD_W != 32) begin : g_bad_word
      $error("sg_stream_walker: descriptor words are 32 bits");
   end
   if (BUF_W < 1 || BUF_W > SGW_FINAL_BIT) begin : g_bad_buf
      $error("sg_stream_walker: BUF_W must lie in 1..31");
   end
   if (AW < 3 || AW > WORD_W) begin : g_bad_aw
      $error("sg_stream_walker: AW must lie in 3..WORD_W");
   end

   sgw_state_e        state_q, state_d;
   logic [AW-1:0]     desc_q, desc_d;
   logic [AW-1:0]     addr_q, addr_d;
   logic [BUF_W-1:0]  rem_q, rem_d;
   logic              fin_q, fin_d;
   logic [WORD_W-1:0] word_q, word_d;
   logic              accum_q, err_q, done_q, pad_q;
   logic [TOT_W-1:0]  total_q;
   logic              audit_clear, audit_add, audit_mismatch;
   logic              fire;

   wire [AW-1:0] next_desc = desc_q + AW'(SGW_DESC_STRIDE);
   wire [AW-1:0] word_base = {addr_q[AW-1:SEL_W], {SEL_W{1'b0}}};
   wire          lane_end  = &addr_q[SEL_W-1:0];

   assign fire = out_valid && out_ready;

   // walk sequencer
   always_comb begin
      state_d     = state_q;
      desc_d      = desc_q;
      addr_d      = addr_q;
      rem_d       = rem_q;
      fin_d       = fin_q;
      word_d      = word_q;
      audit_clear = 1'b0;
      audit_add   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               desc_d      = {list_base[AW-1:SEL_W], {SEL_W{1'b0}}};
               audit_clear = 1'b1;
               state_d     = ST_LEN_REQ;
            end
         end
         ST_LEN_REQ:  if (mem_req_ready) state_d = ST_LEN_WAIT;
         ST_LEN_WAIT: begin
            if (mem_rsp_valid) begin
               rem_d     = mem_rsp_data[BUF_W-1:0];
               fin_d     = mem_rsp_data[SGW_FINAL_BIT];
               audit_add = 1'b1;
               state_d   = ST_PTR_REQ;
            end
         end
         ST_PTR_REQ:  if (mem_req_ready) state_d = ST_PTR_WAIT;
         ST_PTR_WAIT: begin
            if (mem_rsp_valid) begin
               addr_d = mem_rsp_data[AW-1:0];
               if (rem_q != '0) begin
                  state_d = ST_DAT_REQ;
               end else if (fin_q) begin
                  state_d = ST_FINISH;
               end else begin
                  desc_d  = next_desc;
                  state_d = ST_LEN_REQ;
               end
            end
         end
         ST_DAT_REQ:  if (mem_req_ready) state_d = ST_DAT_WAIT;
         ST_DAT_WAIT: begin
            if (mem_rsp_valid) begin
               word_d  = mem_rsp_data;
               state_d = ST_EMIT;
            end
         end
         ST_EMIT: begin
            if (fire) begin
               addr_d = addr_q + AW'(1);
               rem_d  = rem_q - BUF_W'(1);
               if (rem_q == BUF_W'(1)) begin
                  if (fin_q) begin
                     state_d = ST_FINISH;
                  end else begin
                     desc_d  = next_desc;
                     state_d = ST_LEN_REQ;
                  end
               end else if (lane_end) begin
                  state_d = ST_DAT_REQ;
               end
            end
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         desc_q  <= '0;
         addr_q  <= '0;
         rem_q   <= '0;
         fin_q   <= 1'b0;
         word_q  <= '0;
         accum_q <= 1'b0;
         total_q <= '0;
         err_q   <= 1'b0;
         pad_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         desc_q  <= desc_d;
         addr_q  <= addr_d;
         rem_q   <= rem_d;
         fin_q   <= fin_d;
         word_q  <= word_d;
         done_q  <= (state_q == ST_FINISH);
         if (state_q == ST_IDLE && start) begin
            accum_q <= accum_mode;
            total_q <= total_len;
            err_q   <= 1'b0;
            pad_q   <= 1'b0;
         end else if (state_q == ST_FINISH) begin
            err_q <= audit_mismatch;
            pad_q <= !accum_q;
         end
      end
   end

   // memory request port
   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_addr  = '0;
      case (state_q)
         ST_LEN_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = desc_q;
         end
         ST_PTR_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = desc_q + AW'(SGW_PTR_OFFSET);
         end
         ST_DAT_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = word_base;
         end
         default: ;
      endcase
   end

   sgw_lane_pick #(
      .WORD_W (WORD_W),
      .LANE_W (SGW_LANE_W)
   ) u_lane (
      .word     (word_q),
      .sel      (addr_q[SEL_W-1:0]),
      .lane_out (out_data)
   );

   sgw_len_audit #(
      .BUF_W (BUF_W),
      .TOT_W (TOT_W)
   ) u_audit (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (audit_clear),
      .add_en   (audit_add),
      .add_len  (mem_rsp_data[BUF_W-1:0]),
      .total    (total_q),
      .mismatch (audit_mismatch)
   );

   assign out_valid  = (state_q == ST_EMIT);
   assign out_last   = out_valid && fin_q && (rem_q == BUF_W'(1));
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign len_error  = err_q;
   assign pad_needed = pad_q;

   // checks beside the logic they guard
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   assert_noreq_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_req_valid);

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !busy);

   assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_ignore_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !done && $stable(busy) |=> busy || done);
endmodule

// File: tb/tb_sg_stream_walker.sv
module tb_sg_stream_walker;
   localparam int AW = 32, BUF_W = 31, TOT_W = 16, WORD_W = 32;
   localparam int MEM_BYTES = 2048;
   localparam int LIST_AT = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [AW-1:0]     list_base = '0;
   logic [TOT_W-1:0]  total_len = '0;
   logic              accum_mode = 1'b0;
   logic              mem_req_valid, mem_req_ready;
   logic [AW-1:0]     mem_req_addr;
   logic              mem_rsp_valid;
   logic [WORD_W-1:0] mem_rsp_data;
   logic              out_valid, out_ready, out_last;
   logic [7:0]        out_data;
   logic              busy, done, len_error, pad_needed;

   always #2 clk = ~clk;

   sg_stream_walker #(.AW(AW), .BUF_W(BUF_W), .TOT_W(TOT_W), .WORD_W(WORD_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
      .total_len(total_len), .accum_mode(accum_mode),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .busy(busy), .done(done),
      .len_error(len_error), .pad_needed(pad_needed));

   logic [7:0] mem [MEM_BYTES];
   int checks = 0, fails = 0;
   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];
   logic       got_last[$];
   int  done_cnt = 0;
   logic seen_err = 1'b0, seen_pad = 1'b0;
   bit  pend = 0;
   int  pend_dly = 0;
   logic [AW-1:0] pend_addr = '0;
   bit  hold = 0;
   logic [7:0] hold_data = '0;
   logic hold_last = 1'b0;
   int  dl [16];
   int  doff [16];

   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      out_ready     = 1'b0;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input logic [AW-1:0] a);
      int b;
      b = int'(a) & (MEM_BYTES - 4);
      return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
   endfunction

   // memory model and stream sink, both acting away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (pend_dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd_word(pend_addr);
               pend = 0;
            end else begin
               pend_dly--;
            end
         end
         mem_req_ready = ($urandom_range(99) < 70);
         if (mem_req_valid)
            chk(mem_req_addr[1:0] == 2'b00, "R5 aligned request", mem_req_addr, 0);
         if (mem_req_valid && mem_req_ready) begin
            pend      = 1;
            pend_addr = mem_req_addr;
            pend_dly  = int'($urandom_range(2));
         end
         if (hold)
            chk(out_valid && out_data == hold_data && out_last == hold_last,
                "R7 byte held under stall", {out_valid, out_data}, {1'b1, hold_data});
         if (out_valid)
            chk(!mem_req_valid, "R7 no request while byte waits", mem_req_valid, 0);
         out_ready = ($urandom_range(99) < 60);
         hold = out_valid && !out_ready;
         hold_data = out_data;
         hold_last = out_last;
         if (out_valid && out_ready) begin
            got_q.push_back(out_data);
            got_last.push_back(out_last);
         end
         if (done) begin
            done_cnt++;
            seen_err = len_error;
            seen_pad = pad_needed;
         end
      end
   end

   task automatic put_word(input int a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) mem[(a + k) % MEM_BYTES] = w[8*k +: 8];
   endtask

   task automatic run_walk(input int n, input bit accum, input int delta,
                           input bit poke, input bit padded, input string tag);
      int sum, cyc, a;
      logic [7:0] b;
      bit empty_tail;
      sum = 0;
      exp_q.delete();
      for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'($urandom);
      for (int i = 0; i < n; i++) begin
         a = 512 + i * 96 + doff[i];
         for (int k = 0; k < dl[i]; k++) begin
            if (padded) b = (k == 0) ? 8'h61 : (k == 1) ? 8'h62 : (k == 2) ? 8'h63 :
                            (k == 3) ? 8'h80 : (k == dl[i] - 1) ? 8'h18 : 8'h00;
            else b = 8'($urandom);
            mem[a + k] = b;
            exp_q.push_back(b);
         end
         sum += dl[i];
         put_word(LIST_AT + 8 * i, 32'(dl[i]) | ((i == n - 1) ? 32'h8000_0000 : 32'h0));
         put_word(LIST_AT + 8 * i + 4, 32'(a));
      end
      // a stray descriptor after the marked one must never be used
      put_word(LIST_AT + 8 * n, 32'd5);
      put_word(LIST_AT + 8 * n + 4, 32'd256);
      empty_tail = (dl[n-1] == 0);
      @(negedge clk);
      got_q.delete();
      got_last.delete();
      done_cnt = 0;
      list_base  = AW'(LIST_AT);
      total_len  = TOT_W'(sum + delta);
      accum_mode = accum;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (done_cnt == 0 && cyc < 6000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 6) begin
            list_base = AW'(LIST_AT + 8 * n);
            total_len = '0;
            accum_mode = !accum;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      if (cyc >= 6000) chk(0, {"R8 walk completes ", tag}, cyc, 0);
      repeat (3) @(negedge clk);
      chk(done_cnt == 1, {"R8 single done pulse ", tag}, done_cnt, 1);
      chk(!busy, {"R8 idle after done ", tag}, busy, 0);
      chk(got_q.size() == exp_q.size(), {"R3 stream length ", tag}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         chk(got_q[i] == exp_q[i], {"R2 R4 byte order ", tag}, got_q[i], exp_q[i]);
         chk(got_last[i] == (i == exp_q.size() - 1 && !empty_tail),
             {"R6 last flag ", tag}, got_last[i], (i == exp_q.size() - 1 && !empty_tail));
      end
      chk(seen_err == (delta != 0), {"R9 length audit ", tag}, seen_err, delta != 0);
      chk(seen_pad == !accum, {"R10 padding request ", tag}, seen_pad, !accum);
      chk(len_error == (delta != 0), {"R9 error holds ", tag}, len_error, delta != 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd424242));
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(!out_valid && !mem_req_valid, "R1 reset outputs", {out_valid, mem_req_valid}, 0);
      chk(!busy && !done && !len_error && !pad_needed, "R1 reset status",
          {busy, done, len_error, pad_needed}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !out_valid, "R1 idle after release", {busy, out_valid}, 0);

      // 6, 3, 3 byte buffers joined into one message
      dl[0] = 6; dl[1] = 3; dl[2] = 3; doff[0] = 0; doff[1] = 0; doff[2] = 0;
      run_walk(3, 0, 0, 0, 0, "three_buffers");
      // pre-padded message passes unchanged, no padding requested
      dl[0] = 64; doff[0] = 0;
      run_walk(1, 1, 0, 0, 1, "accum_R10");
      // unaligned starts at every lane offset
      for (int i = 0; i < 4; i++) begin dl[i] = 5 + i; doff[i] = i; end
      run_walk(4, 0, 0, 0, 0, "unaligned_R5");
      // empty descriptor in the middle and as the final entry
      dl[0] = 4; dl[1] = 0; dl[2] = 7; dl[3] = 0;
      doff[0] = 1; doff[1] = 2; doff[2] = 3; doff[3] = 0;
      run_walk(4, 0, 0, 0, 0, "empty_R11");
      // single byte buffer
      dl[0] = 1; doff[0] = 3;
      run_walk(1, 0, 0, 0, 0, "one_byte");
      // total length disagrees with descriptors
      dl[0] = 9; dl[1] = 2; doff[0] = 2; doff[1] = 1;
      run_walk(2, 0, 1, 0, 0, "mismatch_R9");
      // start while busy has no effect
      dl[0] = 20; dl[1] = 11; doff[0] = 1; doff[1] = 0;
      run_walk(2, 0, 0, 1, 0, "restart_R12");

      for (int t = 0; t < 24; t++) begin
         int n;
         n = 1 + int'($urandom_range(5));
         for (int i = 0; i < n; i++) begin
            dl[i]   = int'($urandom_range(12));
            doff[i] = int'($urandom_range(3));
         end
         run_walk(n, bit'($urandom_range(1)), (t % 5 == 0) ? -1 : 0, 0, 0, "random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule